// File: doc/BRIEF.md
# CPU Bus Access Wait-State Generator

This block decides how many master clocks each CPU bus cycle lasts. When a cycle starts, the block classifies the cycle from three things: the 24-bit address, an internal-cycle flag and a fast-ROM enable bit. The result is one of three lengths: fast, slow or extra-slow. The block then times the cycle and pulses `done_o` in its last master clock. The CPU side holds `valid_i` while it wants cycles to run, and it moves to its next cycle after each done pulse.

Once per scanline the video side raises a refresh request. The block then freezes the bus for a fixed number of master clocks.

- If no cycle is in progress, the freeze starts at once.
- If a cycle is in progress, the request is held until that cycle ends.
- Only after the freeze has counted out does the next bus cycle begin.

The length picked for the current cycle is visible on `len_o`.

Top module: `bus_wait_gen`

## Requirements
- R1: While `rst_ni` is low and after it rises with no activity, `done_o` is 0 and `len_o` is 0.
- R2: A cycle with `internal_i` high lasts 6 clocks whatever the address and fast-ROM bit.
- R3: Accesses to banks 0x7E and 0x7F, and to offsets 0x0000–0x1FFF of banks 0x00–0x3F and 0x80–0xBF, last 8 clocks.
- R4: Accesses to offsets 0x2000–0x5FFF of banks 0x00–0x3F and 0x80–0xBF last 6 clocks, except the two serial-port addresses of R5.
- R5: Accesses to offsets 0x4016 and 0x4017 of banks 0x00–0x3F and 0x80–0xBF last 12 clocks.
- R6: With `fastrom_i` high, offsets 0x8000–0xFFFF of banks 0x80–0xBF and all of banks 0xC0–0xFF last 6 clocks. Every other address not covered above lasts 8 clocks, as do these regions when `fastrom_i` is low.
- R7: The clock edge that samples `valid_i` high with the block idle starts a cycle and loads `len_o`. The cycle then occupies exactly `len_o` clocks, with `done_o` high only in the last one. With `valid_i` still high, the next cycle starts at the edge that ends the current one.
- R8: The length is fixed when the cycle starts. Changing `fastrom_i` or `addr_i` during the cycle changes neither `len_o` nor the position of its `done_o`.
- R9: A refresh request while idle starts a 40-clock stall at once, and the stall wins over a simultaneous `valid_i`. No cycle starts and `done_o` stays low during the stall. A pending cycle starts at the edge that ends the stall.
- R10: A refresh request during a cycle does not shorten or lengthen that cycle. The 40-clock stall is inserted after the cycle's `done_o` and before the next cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 24 | Bus address, bank in bits 23:16 |
| valid_i | input | 1 | CPU requests a bus cycle |
| internal_i | input | 1 | Cycle does not access memory |
| fastrom_i | input | 1 | Fast-ROM enable |
| refresh_req_i | input | 1 | Refresh stall request, one clock or longer |
| done_o | output | 1 | High in the last clock of a bus cycle |
| len_o | output | 4 | Length in clocks of the current or last cycle |

## Verification
The hardest case to reach is a refresh request that lands inside a running cycle. Deferring it only shows when the pulse arrives several clocks after the cycle starts and a next cycle is already waiting behind it.

The bench starts a 12-clock serial-port cycle and pulses the refresh on the third clock of that cycle. It holds `valid_i` for a following internal cycle. It then checks three positions: the first `done_o` at clock 12, a silent 40-clock gap, and the second `done_o` at clock 58.

A second directed case raises the refresh together with `valid_i` from idle, to show that the stall wins.

// File: rtl/bwg_pkg.sv
package bwg_pkg;
  typedef enum logic [1:0] {SPD_FAST, SPD_SLOW, SPD_XSLOW} spd_e;
  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_STALL} st_e;
endpackage

// File: rtl/bwg_decode.sv
module bwg_decode
  import bwg_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter logic [15:0] LOW_LIM   = 16'h2000,
  parameter logic [15:0] REG_HI    = 16'h5FFF,
  parameter logic [15:0] PORT_BASE = 16'h4016,
  parameter logic [7:0]  WRAM_BANK = 8'h7E
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              internal_i,
  input  logic              fastrom_i,
  output spd_e              spd_o
);
  localparam int OFF_W = 16;
  localparam int BANK_W = ADDR_W - OFF_W;

  logic [BANK_W-1:0] bank;
  logic [OFF_W-1:0]  off;
  logic low_bank, wram_hit, port_hit, reg_hit, fast_hit;

  assign bank = addr_i[ADDR_W-1:OFF_W];
  assign off  = addr_i[OFF_W-1:0];

  // banks 00-3F and 80-BF share the low system map
  assign low_bank = ~bank[BANK_W-2];
  assign wram_hit = (bank[BANK_W-1:1] == WRAM_BANK[BANK_W-1:1]) ||
                    (low_bank && (off < LOW_LIM));
  assign port_hit = low_bank && (off[OFF_W-1:1] == PORT_BASE[OFF_W-1:1]);
  assign reg_hit  = low_bank && (off >= LOW_LIM) && (off <= REG_HI);
  assign fast_hit = fastrom_i && bank[BANK_W-1] && (!low_bank || off[OFF_W-1]);

  always_comb begin
    if (internal_i)    spd_o = SPD_FAST;
    else if (port_hit) spd_o = SPD_XSLOW;
    else if (wram_hit) spd_o = SPD_SLOW;
    else if (reg_hit)  spd_o = SPD_FAST;
    else if (fast_hit) spd_o = SPD_FAST;
    else               spd_o = SPD_SLOW;
  end
endmodule

// File: rtl/bwg_len_sel.sv
module bwg_len_sel
  import bwg_pkg::*;
#(
  parameter int LEN_W     = 4,
  parameter int LEN_FAST  = 6,
  parameter int LEN_SLOW  = 8,
  parameter int LEN_XSLOW = 12
) (
  input  spd_e             spd_i,
  output logic [LEN_W-1:0] len_o
);
  always_comb begin
    unique case (spd_i)
      SPD_FAST:  len_o = LEN_W'(LEN_FAST);
      SPD_XSLOW: len_o = LEN_W'(LEN_XSLOW);
      default:   len_o = LEN_W'(LEN_SLOW);
    endcase
  end
endmodule

// File: rtl/bwg_seq.sv
module bwg_seq
  import bwg_pkg::*;
#(
  parameter int LEN_W       = 4,
  parameter int CNT_W       = 6,
  parameter int REFRESH_LEN = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [LEN_W-1:0] len_sel_i,
  input  logic             refresh_req_i,
  output logic             done_o,
  output logic [LEN_W-1:0] len_o
);
  localparam logic [CNT_W-1:0] STALL_END = CNT_W'(REFRESH_LEN);
  localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

  st_e              st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             pend_q, pend_d;
  logic             req_any, cyc_end, stall_end, gap;

  assign req_any   = pend_q | refresh_req_i;
  assign cyc_end   = (st_q == ST_BUSY) && (cnt_q == CNT_W'(len_q));
  assign stall_end = (st_q == ST_STALL) && (cnt_q == STALL_END);
  assign gap       = (st_q == ST_IDLE) || cyc_end || stall_end;

  always_comb begin
    st_d   = st_q;
    cnt_d  = CNT_W'(cnt_q + CNT_ONE);
    len_d  = len_q;
    pend_d = req_any;
    if (gap) begin
      pend_d = 1'b0;
      if (req_any) begin
        st_d  = ST_STALL;
        cnt_d = CNT_ONE;
      end else if (valid_i) begin
        st_d  = ST_BUSY;
        cnt_d = CNT_ONE;
        len_d = len_sel_i;
      end else begin
        st_d  = ST_IDLE;
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      len_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      len_q  <= len_d;
      pend_q <= pend_d;
    end
  end

  assign done_o = cyc_end;
  assign len_o  = len_q;

  // R7
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  len_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BUSY && !done_o) |=> $stable(len_o));

  // R9
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_STALL && !stall_end) |=> (st_q == ST_STALL && !done_o));

  // R10
  refresh_defer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BUSY && !done_o && refresh_req_i) |=> (st_q == ST_BUSY));

  // R10
  stall_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && req_any) |=> (st_q == ST_STALL && !done_o));
endmodule

// File: rtl/bus_wait_gen.sv
module bus_wait_gen
  import bwg_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int LEN_FAST    = 6,
  parameter int LEN_SLOW    = 8,
  parameter int LEN_XSLOW   = 12,
  parameter int REFRESH_LEN = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              valid_i,
  input  logic              internal_i,
  input  logic              fastrom_i,
  input  logic              refresh_req_i,
  output logic              done_o,
  output logic [3:0]        len_o
);
  localparam int LEN_MAX = (LEN_XSLOW > LEN_SLOW) ? LEN_XSLOW : LEN_SLOW;
  localparam int LEN_W   = $clog2(LEN_MAX + 1);
  localparam int CNT_MAX = (REFRESH_LEN > LEN_MAX) ? REFRESH_LEN : LEN_MAX;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  spd_e             spd;
  logic [LEN_W-1:0] len_sel, len_q;

  bwg_decode #(.ADDR_W(ADDR_W)) decode_i (
    .addr_i(addr_i), .internal_i(internal_i), .fastrom_i(fastrom_i), .spd_o(spd)
  );

  bwg_len_sel #(
    .LEN_W(LEN_W), .LEN_FAST(LEN_FAST), .LEN_SLOW(LEN_SLOW), .LEN_XSLOW(LEN_XSLOW)
  ) len_sel_i (
    .spd_i(spd), .len_o(len_sel)
  );

  bwg_seq #(.LEN_W(LEN_W), .CNT_W(CNT_W), .REFRESH_LEN(REFRESH_LEN)) seq_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .len_sel_i(len_sel),
    .refresh_req_i(refresh_req_i), .done_o(done_o), .len_o(len_q)
  );

  assign len_o = 4'(len_q);

  // R7
  done_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (len_o != 4'd0));
endmodule

// File: tb/bus_wait_gen_tb_top.sv
module bus_wait_gen_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [23:0] addr_i = '0;
  logic        valid_i = 1'b0;
  logic        internal_i = 1'b0;
  logic        fastrom_i = 1'b0;
  logic        refresh_req_i = 1'b0;
  logic        done_o;
  logic [3:0]  len_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk_i = ~clk_i;

  bus_wait_gen dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .valid_i(valid_i),
    .internal_i(internal_i), .fastrom_i(fastrom_i), .refresh_req_i(refresh_req_i),
    .done_o(done_o), .len_o(len_o)
  );

  // {addr, internal, fastrom, expected length, requirement number}
  typedef struct packed {
    logic [23:0] addr;
    logic        intl;
    logic        fast;
    logic [3:0]  exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{24'h7E1234, 1'b0, 1'b1, 4'd8,  4'd3},
    '{24'h7FFFFF, 1'b0, 1'b0, 4'd8,  4'd3},
    '{24'h001FFF, 1'b0, 1'b1, 4'd8,  4'd3},
    '{24'h802000, 1'b0, 1'b0, 4'd6,  4'd4},
    '{24'h3F5FFF, 1'b0, 1'b0, 4'd6,  4'd4},
    '{24'h004018, 1'b0, 1'b0, 4'd6,  4'd4},
    '{24'h004016, 1'b0, 1'b0, 4'd12, 4'd5},
    '{24'h804017, 1'b0, 1'b1, 4'd12, 4'd5},
    '{24'h006000, 1'b0, 1'b1, 4'd8,  4'd6},
    '{24'h808000, 1'b0, 1'b1, 4'd6,  4'd6},
    '{24'h808000, 1'b0, 1'b0, 4'd8,  4'd6},
    '{24'h806000, 1'b0, 1'b1, 4'd8,  4'd6},
    '{24'hC00000, 1'b0, 1'b1, 4'd6,  4'd6},
    '{24'h408000, 1'b0, 1'b1, 4'd8,  4'd6},
    '{24'h7E0000, 1'b1, 1'b0, 4'd6,  4'd2},
    '{24'h004016, 1'b1, 1'b0, 4'd6,  4'd2}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // counts clocks from start edge to done; returns at the negedge showing done
  task automatic wait_done(output int n);
    n = 1;
    while (!done_o && n < 200) begin
      @(negedge clk_i);
      n++;
    end
  endtask

  task automatic run_one(input logic [23:0] a, input logic intl, input logic fast,
                         output int n);
    @(negedge clk_i);
    addr_i = a; internal_i = intl; fastrom_i = fast; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    wait_done(n);
    @(negedge clk_i);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, n1, n2;
    repeat (3) @(negedge clk_i);
    check("R1 done in reset", int'(done_o), 0);
    check("R1 len in reset", int'(len_o), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R1 done after reset", int'(done_o), 0);
    check("R1 len after reset", int'(len_o), 0);

    // table walk: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      addr_i = VECS[i].addr; internal_i = VECS[i].intl;
      fastrom_i = VECS[i].fast; valid_i = 1'b1;
      @(negedge clk_i);
      valid_i = 1'b0;
      check($sformatf("R%0d len_o vec %0d", VECS[i].req, i), int'(len_o), int'(VECS[i].exp));
      wait_done(n);
      check($sformatf("R%0d duration vec %0d", VECS[i].req, i), n, int'(VECS[i].exp));
      @(negedge clk_i);
      check("R7 done one clock", int'(done_o), 0);
    end

    // R7 back-to-back: 12 then 6, valid held
    @(negedge clk_i);
    addr_i = 24'h004017; internal_i = 1'b0; fastrom_i = 1'b0; valid_i = 1'b1;
    @(negedge clk_i);
    wait_done(n1);
    internal_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    check("R7 back-to-back len", int'(len_o), 6);
    wait_done(n2);
    check("R7 back-to-back first", n1, 12);
    check("R7 back-to-back second", n2, 6);
    @(negedge clk_i);

    // R8 fast-ROM bit dropped mid-cycle
    @(negedge clk_i);
    addr_i = 24'hC00000; internal_i = 1'b0; fastrom_i = 1'b1; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0; fastrom_i = 1'b0; addr_i = 24'h004016;
    wait_done(n);
    check("R8 fast held", n, 6);
    check("R8 len held fast", int'(len_o), 6);
    @(negedge clk_i);

    // R8 fast-ROM bit raised mid-cycle
    @(negedge clk_i);
    addr_i = 24'hC00000; fastrom_i = 1'b0; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0; fastrom_i = 1'b1;
    wait_done(n);
    check("R8 slow held", n, 8);
    check("R8 len held slow", int'(len_o), 8);
    @(negedge clk_i);

    // R9 refresh with valid from idle: stall wins
    @(negedge clk_i);
    addr_i = 24'h7E0000; internal_i = 1'b1; fastrom_i = 1'b0;
    valid_i = 1'b1; refresh_req_i = 1'b1;
    @(negedge clk_i);
    refresh_req_i = 1'b0;
    n = 1;
    while (!done_o && n < 200) begin
      @(negedge clk_i);
      n++;
    end
    valid_i = 1'b0;
    check("R9 stall then cycle", n, 46);
    @(negedge clk_i);

    // R10 refresh during a 12-clock cycle, internal cycle queued
    @(negedge clk_i);
    addr_i = 24'h004016; internal_i = 1'b0; valid_i = 1'b1;
    @(negedge clk_i);
    n = 1; n1 = 0; n2 = 0;
    while (n2 == 0 && n < 200) begin
      if (n == 3) refresh_req_i = 1'b1;
      else refresh_req_i = 1'b0;
      if (done_o) begin
        if (n1 == 0) begin
          n1 = n;
          internal_i = 1'b1;
        end else begin
          n2 = n;
          valid_i = 1'b0;
        end
      end
      @(negedge clk_i);
      n++;
    end
    refresh_req_i = 1'b0;
    check("R10 first done unchanged", n1, 12);
    check("R10 stall inserted", n2, 58);
    repeat (2) @(negedge clk_i);
    check("R10 idle after", int'(done_o), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule